// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit load/store instruction into the control word for a single-cycle datapath. It has no clock and no state. It covers four instruction kinds: register-to-register arithmetic, load word, store word and branch-if-equal. For each kind it drives the destination-register select, the second-operand select, the writeback-source select, the register-file write enable, the memory read and write enables, the branch flag and a 2-bit ALU operation class.

Decoding happens in two levels. The main decoder maps the opcode to the control word, including the ALU operation class. A second decoder combines that class with the function field to produce the 4-bit code that drives the ALU. The second level is built from a minimized set of gate equations by default; a parameter selects a case-table variant instead. An opcode outside the supported set clears every control output and raises an illegal-instruction flag, so an unknown instruction cannot change architectural state.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register form) gives dst_sel_o=1, imm_sel_o=0, wb_mem_sel_o=0, rf_we_o=1, dmem_re_o=0, dmem_we_o=0, branch_o=0, alu_class_o=10, illegal_o=0.
- R2: Opcode 100011 (load word) gives dst_sel_o=0, imm_sel_o=1, wb_mem_sel_o=1, rf_we_o=1, dmem_re_o=1, dmem_we_o=0, branch_o=0, alu_class_o=00, illegal_o=0.
- R3: Opcode 101011 (store word) gives imm_sel_o=1, rf_we_o=0, dmem_re_o=0, dmem_we_o=1, branch_o=0, alu_class_o=00, illegal_o=0. dst_sel_o and wb_mem_sel_o are unconstrained.
- R4: Opcode 000100 (branch-if-equal) gives imm_sel_o=0, rf_we_o=0, dmem_re_o=0, dmem_we_o=0, branch_o=1, alu_class_o=01, illegal_o=0. dst_sel_o and wb_mem_sel_o are unconstrained.
- R5: When alu_class_o is 00, alu_ctl_o is 0010 (add) for every value of funct_i.
- R6: When alu_class_o is 01, alu_ctl_o is 0110 (subtract) for every value of funct_i.
- R7: When alu_class_o is 10, funct_i selects the ALU code: 100000 gives 0010 (add), 100010 gives 0110 (sub), 100100 gives 0000 (and), 100101 gives 0001 (or), 101010 gives 0111 (set-less-than).
- R8: For every funct_i with alu_class_o=10, alu_ctl_o obeys the minimized equations: bit3=0, bit2=(class[1] AND F1) OR class[0], bit1=NOT class[1] OR NOT F2, bit0=class[1] AND (F3 OR F0), where Fn is bit n of funct_i.
- R9: Any other opcode drives every control output to 0 (alu_class_o=00, so alu_ctl_o=0010) and sets illegal_o=1.
- R10: dmem_re_o and dmem_we_o are never both 1, and branch_o=1 never comes with rf_we_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field |
| dst_sel_o | output | 1 | 1 selects the rd field as write register, 0 selects rt |
| imm_sel_o | output | 1 | 1 selects the sign-extended immediate as the second ALU operand |
| wb_mem_sel_o | output | 1 | 1 writes back memory data, 0 the ALU result |
| rf_we_o | output | 1 | Register-file write enable |
| dmem_re_o | output | 1 | Data memory read enable |
| dmem_we_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch instruction |
| alu_class_o | output | 2 | ALU operation class: 00 add, 01 subtract, 10 from function field |
| alu_ctl_o | output | 4 | ALU control code |
| illegal_o | output | 1 | Opcode outside the supported set |

## Verification
The immediate assertions re-check properties for every input value the block sees. They cover the safety rules: no memory read with a write, no branch with a register write, and an illegal opcode never enabling state changes. They also cover the fixed add and subtract codes for the two non-register classes, the zero top bit of the ALU code, and agreement between the equation set and the case table on known function codes. The exact control word for each opcode, the full function-code mapping and the don't-care handling for store and branch are shown only by the bench. It sweeps all 4096 opcode and function pairs against values computed from the requirements.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int CLASS_W = 2;
  localparam int ACTL_W  = 4;

  typedef logic [OPC_W-1:0]   opc_t;
  typedef logic [FN_W-1:0]    fn_t;
  typedef logic [ACTL_W-1:0]  actl_t;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } alu_class_t;

  localparam opc_t OPC_REG   = 6'b000000;
  localparam opc_t OPC_LOAD  = 6'b100011;
  localparam opc_t OPC_STORE = 6'b101011;
  localparam opc_t OPC_BEQ   = 6'b000100;

  localparam fn_t FN_ADD = 6'b100000;
  localparam fn_t FN_SUB = 6'b100010;
  localparam fn_t FN_AND = 6'b100100;
  localparam fn_t FN_OR  = 6'b100101;
  localparam fn_t FN_SLT = 6'b101010;

  localparam actl_t ACTL_AND = 4'b0000;
  localparam actl_t ACTL_OR  = 4'b0001;
  localparam actl_t ACTL_ADD = 4'b0010;
  localparam actl_t ACTL_SUB = 4'b0110;
  localparam actl_t ACTL_SLT = 4'b0111;

  typedef struct packed {
    logic       dst_sel;
    logic       imm_sel;
    logic       wb_mem_sel;
    logic       rf_we;
    logic       dmem_re;
    logic       dmem_we;
    logic       branch;
    alu_class_t alu_class;
    logic       illegal;
  } ctrl_word_t;

  // Minimized second-level equations.
  function automatic actl_t alu_ctl_gates(alu_class_t cls, fn_t fn);
    actl_t r;
    r[3] = 1'b0;
    r[2] = (cls[1] & fn[1]) | cls[0];
    r[1] = ~cls[1] | ~fn[2];
    r[0] = cls[1] & (fn[3] | fn[0]);
    return r;
  endfunction

  function automatic logic funct_known(fn_t fn);
    return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
           (fn == FN_OR)  || (fn == FN_SLT);
  endfunction

  // Case-table form; unknown function codes fall back to the equations.
  function automatic actl_t alu_ctl_table(alu_class_t cls, fn_t fn);
    actl_t r;
    case (cls)
      CLS_ADD: r = ACTL_ADD;
      CLS_SUB: r = ACTL_SUB;
      default: begin
        case (fn)
          FN_ADD:  r = ACTL_ADD;
          FN_SUB:  r = ACTL_SUB;
          FN_AND:  r = ACTL_AND;
          FN_OR:   r = ACTL_OR;
          FN_SLT:  r = ACTL_SLT;
          default: r = alu_ctl_gates(cls, fn);
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_dec_pkg::*;
(
  input  opc_t       opcode_i,
  output ctrl_word_t ctrl_o
);

  // First level: one match line per supported instruction kind.
  logic is_reg, is_load, is_store, is_beq, is_known;

  assign is_reg   = (opcode_i == OPC_REG);
  assign is_load  = (opcode_i == OPC_LOAD);
  assign is_store = (opcode_i == OPC_STORE);
  assign is_beq   = (opcode_i == OPC_BEQ);
  assign is_known = is_reg | is_load | is_store | is_beq;

  // Second level: each control is the OR of the kinds that assert it.
  always_comb begin
    ctrl_o            = '0;
    ctrl_o.dst_sel    = is_reg;
    ctrl_o.imm_sel    = is_load | is_store;
    ctrl_o.wb_mem_sel = is_load;
    ctrl_o.rf_we      = is_reg | is_load;
    ctrl_o.dmem_re    = is_load;
    ctrl_o.dmem_we    = is_store;
    ctrl_o.branch     = is_beq;
    ctrl_o.alu_class  = alu_class_t'({is_reg, is_beq});
    ctrl_o.illegal    = ~is_known;
  end

  always_comb begin
    p_one_kind_r9: assert ($onehot0({is_reg, is_load, is_store, is_beq}))
      else $error("p_one_kind_r9: more than one opcode match");
    p_rtype_word_r1: assert (!is_reg || (ctrl_o.dst_sel && ctrl_o.rf_we &&
                             !ctrl_o.imm_sel && ctrl_o.alu_class == CLS_FUNCT))
      else $error("p_rtype_word_r1: register-form control word wrong");
    p_load_word_r2: assert (!is_load || (ctrl_o.wb_mem_sel && ctrl_o.dmem_re &&
                            ctrl_o.rf_we && ctrl_o.alu_class == CLS_ADD))
      else $error("p_load_word_r2: load control word wrong");
  end

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_dec_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
)(
  input  alu_class_t alu_class_i,
  input  fn_t        funct_i,
  output actl_t      alu_ctl_o
);

  actl_t gate_code;
  actl_t table_code;
  logic  fn_known;

  assign gate_code  = alu_ctl_gates(alu_class_i, funct_i);
  assign table_code = alu_ctl_table(alu_class_i, funct_i);
  assign fn_known   = funct_known(funct_i);

  generate
    if (USE_TABLE) begin : g_table
      assign alu_ctl_o = table_code;
    end else begin : g_gates
      assign alu_ctl_o = gate_code;
    end
  endgenerate

  always_comb begin
    p_forms_agree_r7: assert (!(alu_class_i == CLS_FUNCT && fn_known) ||
                              gate_code == table_code)
      else $error("p_forms_agree_r7: equation and table codes differ");
    p_top_bit_zero_r8: assert (alu_ctl_o[ACTL_W-1] == 1'b0)
      else $error("p_top_bit_zero_r8: ALU code bit 3 set");
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
)(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       dst_sel_o,
  output logic       imm_sel_o,
  output logic       wb_mem_sel_o,
  output logic       rf_we_o,
  output logic       dmem_re_o,
  output logic       dmem_we_o,
  output logic       branch_o,
  output logic [1:0] alu_class_o,
  output logic [3:0] alu_ctl_o,
  output logic       illegal_o
);

  ctrl_word_t ctrl;
  actl_t      alu_code;

  ctrl_main_dec u_main (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  ctrl_alu_dec #(.USE_TABLE(USE_TABLE)) u_alu (
    .alu_class_i (ctrl.alu_class),
    .funct_i     (funct_i),
    .alu_ctl_o   (alu_code)
  );

  assign dst_sel_o    = ctrl.dst_sel;
  assign imm_sel_o    = ctrl.imm_sel;
  assign wb_mem_sel_o = ctrl.wb_mem_sel;
  assign rf_we_o      = ctrl.rf_we;
  assign dmem_re_o    = ctrl.dmem_re;
  assign dmem_we_o    = ctrl.dmem_we;
  assign branch_o     = ctrl.branch;
  assign alu_class_o  = ctrl.alu_class;
  assign alu_ctl_o    = alu_code;
  assign illegal_o    = ctrl.illegal;

  always_comb begin
    p_add_class_r5: assert (alu_class_o != 2'b00 || alu_ctl_o == 4'b0010)
      else $error("p_add_class_r5: add class not mapped to 0010");
    p_sub_class_r6: assert (alu_class_o != 2'b01 || alu_ctl_o == 4'b0110)
      else $error("p_sub_class_r6: subtract class not mapped to 0110");
    p_illegal_quiet_r9: assert (!illegal_o ||
                                !(rf_we_o || dmem_re_o || dmem_we_o || branch_o))
      else $error("p_illegal_quiet_r9: illegal opcode enabled a state change");
    p_mem_excl_r10: assert (!(dmem_re_o && dmem_we_o))
      else $error("p_mem_excl_r10: memory read and write together");
    p_branch_nowr_r10: assert (!(branch_o && rf_we_o))
      else $error("p_branch_nowr_r10: branch with register write");
    p_store_word_r3: assert (opcode_i != 6'b101011 ||
                             (dmem_we_o && imm_sel_o && !rf_we_o))
      else $error("p_store_word_r3: store control word wrong");
    p_beq_word_r4: assert (opcode_i != 6'b000100 ||
                           (branch_o && alu_class_o == 2'b01 && !imm_sel_o))
      else $error("p_beq_word_r4: branch control word wrong");
  end

endmodule

// File: tb/ctrl_decoder_bench.sv
module ctrl_decoder_bench;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode, funct;
  logic       dst_sel, imm_sel, wb_mem_sel, rf_we, dmem_re, dmem_we, branch, illegal;
  logic [1:0] alu_class;
  logic [3:0] alu_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_decoder u_ctrl_decoder (
    .opcode_i     (opcode),
    .funct_i      (funct),
    .dst_sel_o    (dst_sel),
    .imm_sel_o    (imm_sel),
    .wb_mem_sel_o (wb_mem_sel),
    .rf_we_o      (rf_we),
    .dmem_re_o    (dmem_re),
    .dmem_we_o    (dmem_we),
    .branch_o     (branch),
    .alu_class_o  (alu_class),
    .alu_ctl_o    (alu_ctl),
    .illegal_o    (illegal)
  );

  // Word order: dst,imm,wbmem,rfwe,re,we,branch,class[1:0],illegal
  function automatic logic [9:0] word_now();
    return {dst_sel, imm_sel, wb_mem_sel, rf_we, dmem_re, dmem_we, branch,
            alu_class, illegal};
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp,
                       logic [9:0] mask, logic [5:0] op, logic [5:0] fn);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b mask=%b",
               req, op, fn, act, exp, mask);
    end
  endtask

  // Expected ALU code built from arithmetic on the class and function field.
  function automatic logic [3:0] exp_alu(logic [1:0] cls, logic [5:0] fn);
    int code;
    if (cls == 2'b00) return 4'd2;
    if (cls == 2'b01) return 4'd6;
    code = 0;
    if (fn[1] == 1'b1)  code += 4;
    if (fn[2] == 1'b0)  code += 2;
    if (fn[3] || fn[0]) code += 1;
    return code[3:0];
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] exp, mask;
    logic [3:0] ea;
    opcode = 6'b111111;
    funct  = 6'b000000;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state before the sweep: illegal opcode, all controls off (R9).
    check("R9 idle", {word_now(), 0 == 1 ? 1'b0 : 1'b0} >> 1, 10'b0000000001,
          10'h3FF, opcode, funct);

    for (int o = 0; o < 64; o++) begin
      for (int f = 0; f < 64; f++) begin
        @(posedge clk);
        opcode = o[5:0];
        funct  = f[5:0];
        @(negedge clk);
        mask = 10'h3FF;
        case (o[5:0])
          6'b000000: exp = 10'b1001000_10_0;               // R1
          6'b100011: exp = 10'b0111100_00_0;               // R2
          6'b101011: begin exp = 10'b0100010_00_0;         // R3
                           mask = 10'b0101111_11_1; end
          6'b000100: begin exp = 10'b0000001_01_0;         // R4
                           mask = 10'b0101111_11_1; end
          default:   exp = 10'b0000000_00_1;               // R9
        endcase
        case (o[5:0])
          6'b000000: check("R1", word_now(), exp, mask, opcode, funct);
          6'b100011: check("R2", word_now(), exp, mask, opcode, funct);
          6'b101011: check("R3", word_now(), exp, mask, opcode, funct);
          6'b000100: check("R4", word_now(), exp, mask, opcode, funct);
          default:   check("R9", word_now(), exp, mask, opcode, funct);
        endcase
        // R10 safety pairs
        check("R10", {8'd0, dmem_re & dmem_we, branch & rf_we}, 10'd0,
              10'h3FF, opcode, funct);
        ea = exp_alu(exp[2:1], funct);
        if (exp[2:1] == 2'b00)
          check("R5", {6'd0, alu_ctl}, {6'd0, ea}, 10'h3FF, opcode, funct);
        else if (exp[2:1] == 2'b01)
          check("R6", {6'd0, alu_ctl}, {6'd0, ea}, 10'h3FF, opcode, funct);
        else
          check("R8", {6'd0, alu_ctl}, {6'd0, ea}, 10'h3FF, opcode, funct);
        // R7: case-table reference for the five defined function codes
        if (o == 0) begin
          case (f[5:0])
            6'b100000: check("R7 add", {6'd0, alu_ctl}, 10'd2, 10'h3FF, opcode, funct);
            6'b100010: check("R7 sub", {6'd0, alu_ctl}, 10'd6, 10'h3FF, opcode, funct);
            6'b100100: check("R7 and", {6'd0, alu_ctl}, 10'd0, 10'h3FF, opcode, funct);
            6'b100101: check("R7 or",  {6'd0, alu_ctl}, 10'd1, 10'h3FF, opcode, funct);
            6'b101010: check("R7 slt", {6'd0, alu_ctl}, 10'd7, 10'h3FF, opcode, funct);
            default: ;
          endcase
          // Equation form and table agree on defined codes (R7, R8)
          if (f == 32 || f == 34 || f == 36 || f == 37 || f == 42) begin
            logic [3:0] tbl;
            tbl = (f == 32) ? 4'd2 : (f == 34) ? 4'd6 : (f == 36) ? 4'd0 :
                  (f == 37) ? 4'd1 : 4'd7;
            check("R8 eq-vs-table", {6'd0, exp_alu(2'b10, funct)}, {6'd0, tbl},
                  10'h3FF, opcode, funct);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule